// File: doc/BRIEF.md
# Clock Controller Register File

This block is the bus-facing register bank of a clock control unit. It holds nine 32-bit configuration words: one general clock control word, two post-divider words, a main and a secondary PLL setting word, three clock-gating words and a power-management word. A word-addressed slave port accepts writes. A second slave port accepts reads and returns registered data one cycle later. Offset 18 is a read-only status word that always returns the same constant.

Each stored word is shaped on the way in. A per-register write mask clears reserved bits. The control word also has one bit that every write forces to 1. The power-management word cannot be written from the bus at all.

A separate frequency calculator takes the stored words. It must run again whenever a word that changes a derived clock frequency is updated. For that, the block issues a one-cycle recalculate request. The request also fires once as the block leaves reset, so the calculator starts from the reset contents.

Top module: `clkctl_regfile`

## Requirements
- R1: After reset the words read as follows, by word offset: 0 = 0x074B0B7B, 1 = 0xFF870B48, 2 = 0x49FCFE7F, 4 = 0x04001800, 6 = 0x04043001, 8, 9 and 10 = 0xFFFFFFFF, 23 = 0x80209828. The values at offsets 4 and 6 come from PLL fields packed as pre-divider [29:26], denominator [25:16], integer [13:10] and numerator [9:0]: (1,0,6,0) at offset 4 and (1,4,12,1) at offset 6.
- R2: A write to word 0 stores (data AND 0x3B6FDFFF) with bit 26 then set to 1.
- R3: A write to word 1 stores (data AND 0xFF9F3FFF). Writes to words 2, 8, 9 and 10 store all 32 bits unchanged.
- R4: A write to word 4 or word 6 stores (data AND 0xBFFF3FFF).
- R5: A write to word 23 leaves its value unchanged.
- R6: Byte address bits [11:2] select the word and bits [1:0] are ignored. A read of word 18 returns 0x00004040. A read of any word not listed in R1 or here returns 0, and a write to such a word changes nothing.
- R7: rd_resp_valid and rd_data appear in the cycle after rd_valid is sampled high. A read and a write in the same cycle to the same word return the value from before the write.
- R8: recalc_req is high for exactly the one cycle after a write to word 0, 1, 2, 4 or 6 is accepted. Back-to-back such writes keep it high for consecutive cycles.
- R9: A write to words 8, 9, 10, 23 or any other word does not raise recalc_req.
- R10: recalc_req is high in the first cycle after reset is released, and low in the cycle after that when no write intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accept, always high |
| wr_addr | input | ADDR_W (12) | Write byte address |
| wr_data | input | 32 | Write data |
| rd_valid | input | 1 | Read request |
| rd_ready | output | 1 | Read accept, always high |
| rd_addr | input | ADDR_W (12) | Read byte address |
| rd_resp_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 32 | Read data |
| recalc_req | output | 1 | One-cycle request to recompute clock frequencies |

## Verification
Two things can land in one clock edge. A read can sample a word in the same edge that a write updates it. A frequency-relevant write can also coincide with the post-reset recalculate request, or follow another such write at once. The random phase issues a read and a write together in many cycles, often to the same word. Each read is judged against the bench model's contents from before that cycle's write. Directed back-to-back writes to the divider and PLL words check that recalc_req stays high for each one.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
   localparam int DATA_W = 32;
   localparam int NREG   = 9;
   typedef logic [DATA_W-1:0] word_t;

   // Pack PLL setting fields: pre-divider, denominator, integer, numerator.
   function automatic word_t pll_pack(input int unsigned pd, input int unsigned den,
                                      input int unsigned ip, input int unsigned num);
      return word_t'(((pd & 32'hF) << 26) | ((den & 32'h3FF) << 16) |
                     ((ip & 32'hF) << 10) | (num & 32'h3FF));
   endfunction

   // Index order: ctrl, div0, div1, pll_main, pll_sec, gate0, gate1, gate2, pm
   localparam int unsigned REG_WORD [NREG] = '{0, 1, 2, 4, 6, 8, 9, 10, 23};
   localparam word_t REG_MASK [NREG] = '{32'h3B6FDFFF, 32'hFF9F3FFF, 32'hFFFFFFFF,
      32'hBFFF3FFF, 32'hBFFF3FFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0};
   localparam word_t REG_FORCE [NREG] = '{32'h04000000, 32'h0, 32'h0, 32'h0, 32'h0,
      32'h0, 32'h0, 32'h0, 32'h0};
   localparam word_t REG_RST [NREG] = '{32'h074B0B7B, 32'hFF870B48, 32'h49FCFE7F,
      pll_pack(1, 0, 6, 0), pll_pack(1, 4, 12, 1), 32'hFFFFFFFF, 32'hFFFFFFFF,
      32'hFFFFFFFF, 32'h80209828};
   localparam logic [NREG-1:0] REG_WRITABLE = 9'b0_1111_1111;
   localparam logic [NREG-1:0] REG_FREQ     = 9'b0_0001_1111;

   localparam int unsigned STATUS_WORD = 18;
   localparam word_t       STATUS_VAL  = 32'h00004040;
   localparam int unsigned MAX_WORD    = 23;
endpackage

// File: rtl/clkctl_wr_decode.sv
module clkctl_wr_decode
   import clkctl_pkg::*;
#(
   parameter int WORD_W = 10
) (
   input  logic                wr_en,
   input  logic [WORD_W-1:0]   word,
   output logic [NREG-1:0]     sel,
   output logic                freq_hit
);
   for (genvar i = 0; i < NREG; i++) begin : g_dec
      assign sel[i] = wr_en && (word == WORD_W'(REG_WORD[i])) && REG_WRITABLE[i];
   end
   assign freq_hit = |(sel & REG_FREQ);
endmodule

// File: rtl/clkctl_reg.sv
module clkctl_reg
   import clkctl_pkg::*;
#(
   parameter word_t RST      = '0,
   parameter word_t MASK     = '1,
   parameter word_t FORCE    = '0,
   parameter bit    WRITABLE = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  we,
   input  word_t wdata,
   output word_t q
);
   if (WRITABLE) begin : g_rw
      word_t q_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  q_r <= RST;
         else if (we) q_r <= (wdata & MASK) | FORCE;
      end
      assign q = q_r;
   end else begin : g_ro
      assign q = RST;
   end
endmodule

// File: rtl/clkctl_rd_mux.sv
module clkctl_rd_mux
   import clkctl_pkg::*;
#(
   parameter int WORD_W = 10
) (
   input  logic [WORD_W-1:0] word,
   input  word_t             regs [NREG],
   output word_t             data
);
   always_comb begin
      data = '0;
      if (word == WORD_W'(STATUS_WORD)) data = STATUS_VAL;
      for (int i = 0; i < NREG; i++) begin
         if (word == WORD_W'(REG_WORD[i])) data = regs[i];
      end
   end
endmodule

// File: rtl/clkctl_regfile.sv
module clkctl_regfile
   import clkctl_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic              rd_valid,
   output logic              rd_ready,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_resp_valid,
   output logic [31:0]       rd_data,
   output logic              recalc_req
);
   localparam int WORD_W = ADDR_W - 2;

   if (WORD_W < $clog2(MAX_WORD + 1)) begin : g_bad_width
      $error("clkctl_regfile: ADDR_W too small for the word map");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("clkctl_regfile: data width must be 32");
   end

   logic [NREG-1:0] sel;
   logic            freq_hit;
   word_t           regs_q [NREG];
   word_t           rd_mux;
   logic            boot_pend_q;
   logic            recalc_q;
   logic            rvalid_q;
   word_t           rdata_q;

   assign wr_ready = 1'b1;
   assign rd_ready = 1'b1;

   clkctl_wr_decode #(.WORD_W(WORD_W)) u_dec (
      .wr_en    (wr_valid),
      .word     (wr_addr[ADDR_W-1:2]),
      .sel      (sel),
      .freq_hit (freq_hit)
   );

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      clkctl_reg #(
         .RST      (REG_RST[i]),
         .MASK     (REG_MASK[i]),
         .FORCE    (REG_FORCE[i]),
         .WRITABLE (REG_WRITABLE[i])
      ) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (sel[i]),
         .wdata (wr_data),
         .q     (regs_q[i])
      );
   end

   clkctl_rd_mux #(.WORD_W(WORD_W)) u_rmux (
      .word (rd_addr[ADDR_W-1:2]),
      .regs (regs_q),
      .data (rd_mux)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         boot_pend_q <= 1'b1;
         recalc_q    <= 1'b0;
         rvalid_q    <= 1'b0;
         rdata_q     <= '0;
      end else begin
         boot_pend_q <= 1'b0;
         recalc_q    <= boot_pend_q | freq_hit;
         rvalid_q    <= rd_valid;
         if (rd_valid) rdata_q <= rd_mux;
      end
   end

   assign recalc_req    = recalc_q;
   assign rd_resp_valid = rvalid_q;
   assign rd_data       = rdata_q;
endmodule

// File: rtl/clkctl_regfile_chk.sv
module clkctl_regfile_chk #(
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              rd_valid,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              rd_resp_valid,
   input logic [31:0]       rd_data,
   input logic              recalc_req
);
   localparam int WORD_W = ADDR_W - 2;
   logic [WORD_W-1:0] ww, rw;
   logic              wfreq;
   assign ww = wr_addr[ADDR_W-1:2];
   assign rw = rd_addr[ADDR_W-1:2];
   assign wfreq = wr_valid && (ww == 0 || ww == 1 || ww == 2 || ww == 4 || ww == 6);

   assert_resp_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> rd_resp_valid);
   assert_status_const_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rw == WORD_W'(18)) |=> rd_data == 32'h00004040);
   assert_ctrl_forced_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rw == WORD_W'(0)) |=> rd_data[26]);
   assert_pm_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rw == WORD_W'(23)) |=> rd_data == 32'h80209828);
   assert_recalc_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wfreq |=> recalc_req);
   assert_recalc_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (recalc_req && !wfreq) |=> !recalc_req);
endmodule

bind clkctl_regfile clkctl_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_valid      (wr_valid),
   .wr_addr       (wr_addr),
   .rd_valid      (rd_valid),
   .rd_addr       (rd_addr),
   .rd_resp_valid (rd_resp_valid),
   .rd_data       (rd_data),
   .recalc_req    (recalc_req)
);

// File: tb/clkctl_regfile_tb.sv
`timescale 1ns/1ps
module clkctl_regfile_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0, rd_valid = 1'b0;
   logic        wr_ready, rd_ready, rd_resp_valid, recalc_req;
   logic [11:0] wr_addr = '0, rd_addr = '0;
   logic [31:0] wr_data = '0, rd_data;
   int          errors = 0, checks = 0;
   bit          done = 1'b0;
   logic [31:0] m [32];

   always #2.5 clk = ~clk;

   clkctl_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
      .rd_addr(rd_addr), .rd_resp_valid(rd_resp_valid), .rd_data(rd_data),
      .recalc_req(recalc_req)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] model_rd(input int w);
      if (w == 18) return 32'h00004040;
      if (w < 32) return m[w];
      return 32'h0;
   endfunction

   function automatic bit is_freq(input int w);
      return (w == 0 || w == 1 || w == 2 || w == 4 || w == 6);
   endfunction

   function automatic void model_wr(input int w, input logic [31:0] d);
      case (w)
         0: m[0] = (d & 32'h3B6FDFFF) | 32'h04000000;
         1: m[1] = d & 32'hFF9F3FFF;
         2, 8, 9, 10: m[w] = d;
         4, 6: m[w] = d & 32'hBFFF3FFF;
         default: ;
      endcase
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 32; i++) m[i] = 32'h0;
      m[0] = 32'h074B0B7B; m[1] = 32'hFF870B48; m[2] = 32'h49FCFE7F;
      m[4] = 32'h04001800; m[6] = 32'h04043001;
      m[8] = 32'hFFFFFFFF; m[9] = 32'hFFFFFFFF; m[10] = 32'hFFFFFFFF;
      m[23] = 32'h80209828;
   endtask

   // Called at a falling edge; drives one cycle of requests and checks results.
   task automatic op(input bit wv, input logic [11:0] wa, input logic [31:0] wd,
                     input bit rv, input logic [11:0] ra, input string tag);
      logic [31:0] exp_rd;
      bit          exp_rc;
      wr_valid = wv; wr_addr = wa; wr_data = wd;
      rd_valid = rv; rd_addr = ra;
      exp_rd = model_rd(int'(ra[11:2]));
      exp_rc = wv && is_freq(int'(wa[11:2]));
      if (wv) model_wr(int'(wa[11:2]), wd);
      @(negedge clk);
      wr_valid = 1'b0; rd_valid = 1'b0;
      check({tag, " rvalid (R7)"}, {31'b0, rd_resp_valid}, {31'b0, rv});
      if (rv) check({tag, " rdata"}, rd_data, exp_rd);
      check({tag, exp_rc ? " recalc (R8)" : " recalc (R9)"}, {31'b0, recalc_req}, {31'b0, exp_rc});
   endtask

   task automatic rd(input int w, input string tag);
      op(1'b0, 12'h0, 32'h0, 1'b1, 12'(w << 2), tag);
   endtask

   task automatic wr_rd(input int w, input logic [31:0] d, input string tag);
      op(1'b1, 12'(w << 2), d, 1'b0, 12'h0, tag);
      rd(w, tag);
   endtask

   initial begin
      void'($urandom(32'd1234));
      model_reset();
      repeat (3) @(negedge clk);
      check("reset rvalid R1", {31'b0, rd_resp_valid}, 32'h0);
      check("reset recalc R10", {31'b0, recalc_req}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("post-reset recalc R10", {31'b0, recalc_req}, 32'h1);
      @(negedge clk);
      check("post-reset recalc drops R10", {31'b0, recalc_req}, 32'h0);
      // R1 reset contents
      foreach (m[i]) if (m[i] != 0) rd(i, "R1 reset value");
      // R6 status, unlisted words, low address bits
      rd(18, "R6 status word");
      rd(3, "R6 unlisted word");
      op(1'b0, 12'h0, 32'h0, 1'b1, 12'h027, "R6 low bits ignored");
      op(1'b0, 12'h0, 32'h0, 1'b1, 12'hFE0, "R6 high unlisted");
      wr_rd(18, 32'h12345678, "R6 status write ignored");
      wr_rd(5, 32'hDEADBEEF, "R6 unlisted write");
      // R2 control masking
      wr_rd(0, 32'hFFFFFFFF, "R2 ctrl ones");
      wr_rd(0, 32'h00000000, "R2 ctrl zero");
      // R3 dividers and gating
      wr_rd(1, 32'hFFFFFFFF, "R3 div0 mask");
      wr_rd(2, 32'hA5A5F00F, "R3 div1 full");
      wr_rd(9, 32'h0F0F1234, "R3 gate1 full");
      // R4 PLLs
      wr_rd(4, 32'hFFFFFFFF, "R4 pll main");
      wr_rd(6, 32'h7FFFC001, "R4 pll sec");
      // R5 power management
      wr_rd(23, 32'h00000000, "R5 pm write ignored");
      // R7 same-cycle read and write
      op(1'b1, 12'h004, 32'h00000000, 1'b1, 12'h004, "R7 collision old value");
      rd(1, "R7 collision new value");
      // R8 back-to-back frequency writes
      op(1'b1, 12'h000, 32'h1, 1'b0, 12'h0, "R8 burst 0");
      op(1'b1, 12'h010, 32'h2, 1'b0, 12'h0, "R8 burst 1");
      op(1'b1, 12'h018, 32'h3, 1'b0, 12'h0, "R8 burst 2");
      op(1'b1, 12'h020, 32'h4, 1'b0, 12'h0, "R9 gate after burst");
      // random mix, frequent same-word collisions
      for (int n = 0; n < 600; n++) begin
         int          ww, rw;
         logic [31:0] d;
         ww = int'($urandom_range(0, 31));
         rw = ($urandom_range(0, 2) == 0) ? ww : int'($urandom_range(0, 31));
         d  = $urandom();
         op(1'($urandom_range(0, 1)), 12'((ww << 2) | $urandom_range(0, 3)), d,
            1'($urandom_range(0, 1)), 12'((rw << 2) | $urandom_range(0, 3)),
            "R7 random mix");
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule